// File: doc/BRIEF.md
# Non-Cacheable Window Checker

This block decides, for every physical bus address, whether the access may be placed in an on-chip cache. It holds a small bank of byte-wide configuration registers: two control bytes and four programmable uncached windows. Each window has a 20-bit start page and a 4-bit logarithmic size code. Software programs the bank by presenting an index and a data byte with a write strobe. Any index can be read back combinationally.

The lookup is purely combinational from the registered configuration. An address is reported cacheable only when it falls in no enabled window and in no enabled fixed legacy hole. A fixed hole covers the display memory area, or the first 64 KB of each megabyte while the processor runs in real or virtual-8086 mode. When the external gating control bit is set, the active-low external cache-enable input must also be low. Each window's base is aligned down to its own size, so a start address that is not aligned is truncated without any warning.

Top module: `uncached_window_unit`

## Requirements
- R1: After reset every configuration byte reads 0 and every address is reported cacheable (`cacheable` = 1).
- R2: With `cfg_wr` high at a clock edge, the byte on `cfg_wdata` is stored at `cfg_idx` and can be read on `cfg_rdata` from the next cycle. Mapped indices: control 0 at C0h and control 1 at C1h. Window k (k = 0..3) uses C4h+3k for address bits 31..24 and C5h+3k for bits 23..16. C6h+3k holds address bits 15..12 in its upper nibble and the size code in its lower nibble.
- R3: Writes to unmapped indices (C2h, C3h, and anything below C0h or above CFh) change nothing, and those indices read 0.
- R4: A window with size code 0 never makes an address uncacheable.
- R5: Size codes 1 to 14 give a window of 2^(11+code) bytes (4 KB up to 32 MB). Addresses inside it are uncacheable; the first address past its end and the last address before its base are not.
- R6: The effective base of a window is the programmed start with every address bit below the window size cleared.
- R7: Size code 15 makes every address uncacheable.
- R8: With control 0 bit 1 set, addresses from A0000h through FFFFFh are uncacheable, and 9FFFFh and 100000h are not.
- R9: With control 0 bit 0 set and `legacy_mode` high, any address whose bits 19..16 are zero is uncacheable. With `legacy_mode` low this bit has no effect.
- R10: With control 0 bit 3 set, `ext_cache_en_n` high forces `cacheable` low. With that bit clear, the input is ignored.
- R11: Control 1 is stored and read back but does not affect the lookup.
- R12: `cacheable` follows `lookup_addr` in the same cycle, with no clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration bank |
| cfg_idx | input | 8 | Register index for write and read |
| cfg_wdata | input | 8 | Byte to store |
| cfg_rdata | output | 8 | Stored byte at `cfg_idx` (0 when unmapped) |
| lookup_addr | input | 32 | Physical address under test |
| legacy_mode | input | 1 | High while in real or virtual-8086 mode |
| ext_cache_en_n | input | 1 | Active-low external cache enable |
| cacheable | output | 1 | High when the address may be cached |

## Verification
The hardest case to reach is a window whose start byte is written while its size code is still 0. The window must stay inert until the last byte arrives. At that point its base must snap to a size boundary below the written start. The stimulus table builds each window one byte at a time and probes the target address after every byte. It then probes both edges of the aligned span: one address just inside and one just outside. The 32 MB and whole-space codes are reached the same way, and the whole-space window is then switched back off.

// File: rtl/ucw_pkg.sv
package ucw_pkg;
    parameter int ADDR_W     = 32;
    parameter int BYTE_W     = 8;
    parameter int CODE_W     = 4;
    parameter int PAGE_SHIFT = 12;
    parameter int NUM_WIN    = 4;
    parameter int CTL_BYTES  = 4;   // C0..C3, of which C2/C3 are holes
    parameter int WIN_BYTES  = 3;
    parameter logic [BYTE_W-1:0] BASE_IDX = 8'hC0;

    localparam int START_W    = ADDR_W - PAGE_SHIFT;
    localparam int SHIFT_BASE = PAGE_SHIFT - 1;
    localparam logic [CODE_W-1:0] CODE_OFF = '0;
    localparam logic [CODE_W-1:0] CODE_ALL = '1;

    typedef struct packed {
        logic [START_W-1:0] start;
        logic [CODE_W-1:0]  code;
    } win_cfg_t;
endpackage

// File: rtl/ucw_cfg_bank.sv
module ucw_cfg_bank
    import ucw_pkg::*;
#(
    parameter int WINS = NUM_WIN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [BYTE_W-1:0]        idx,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    output logic                     low64_en,
    output logic                     video_en,
    output logic                     ext_en,
    output win_cfg_t [WINS-1:0]      win
);
    localparam int DEPTH = CTL_BYTES + WIN_BYTES * WINS;
    localparam int OFF_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] regs;
    } bank_t;

    bank_t state_d, state_q;

    logic [BYTE_W-1:0] off_full;
    logic [OFF_W-1:0]  off;
    logic              mapped;

    always_comb begin
        off_full = idx - BASE_IDX;
        off      = off_full[OFF_W-1:0];
        mapped   = (idx >= BASE_IDX) && (off_full < BYTE_W'(DEPTH))
                   && (off_full != 8'd2) && (off_full != 8'd3);
    end

    always_comb begin
        state_d = state_q;
        if (wr && mapped) begin
            state_d.regs[off] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata    = mapped ? state_q.regs[off] : '0;
    assign low64_en = state_q.regs[0][0];
    assign video_en = state_q.regs[0][1];
    assign ext_en   = state_q.regs[0][3];

    for (genvar k = 0; k < WINS; k++) begin : g_win
        localparam int B0 = CTL_BYTES + WIN_BYTES * k;
        assign win[k].start = {state_q.regs[B0], state_q.regs[B0+1],
                               state_q.regs[B0+2][BYTE_W-1:CODE_W]};
        assign win[k].code  = state_q.regs[B0+2][CODE_W-1:0];
    end

    // R2: a mapped write shows up in the bank one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && mapped) |=> (state_q.regs[$past(off)] == $past(wdata)));

    // R3: an unmapped write leaves the whole bank untouched
    a_r3_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mapped) |=> $stable(state_q.regs));
endmodule

// File: rtl/ucw_window_match.sv
module ucw_window_match
    import ucw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base;

    always_comb begin
        base = {cfg.start, {PAGE_SHIFT{1'b0}}};
        if (cfg.code == CODE_ALL) begin
            mask = '0;
        end else begin
            mask = {ADDR_W{1'b1}} << (SHIFT_BASE + int'(cfg.code));
        end
        hit = (cfg.code != CODE_OFF) && ((addr & mask) == (base & mask));
    end

    // R4: a disabled window never matches
    a_r4_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.code == CODE_OFF) |-> !hit);

    // R7: the whole-space code matches every address
    a_r7_all_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.code == CODE_ALL) |-> hit);

    // R6: an address equal to the raw start always lies in its own window
    a_r6_start_inside: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.code != CODE_OFF) && (addr == base)) |-> hit);
endmodule

// File: rtl/uncached_window_unit.sv
module uncached_window_unit
    import ucw_pkg::*;
#(
    parameter int WINS = NUM_WIN
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_idx,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [31:0] lookup_addr,
    input  logic        legacy_mode,
    input  logic        ext_cache_en_n,
    output logic        cacheable
);
    win_cfg_t [WINS-1:0] win;
    logic [WINS-1:0]     win_hit;
    logic                low64_en, video_en, ext_en;
    logic                video_hole, low64_hole, ext_block;

    ucw_cfg_bank #(.WINS(WINS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .low64_en (low64_en),
        .video_en (video_en),
        .ext_en   (ext_en),
        .win      (win)
    );

    for (genvar k = 0; k < WINS; k++) begin : g_match
        ucw_window_match u_match (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (win[k]),
            .addr  (lookup_addr),
            .hit   (win_hit[k])
        );
    end

    always_comb begin
        video_hole = video_en && (lookup_addr[31:20] == '0)
                     && (lookup_addr[19:17] >= 3'd5);
        low64_hole = low64_en && legacy_mode && (lookup_addr[19:16] == '0);
        ext_block  = ext_en && ext_cache_en_n;
        cacheable  = !(|win_hit) && !video_hole && !low64_hole && !ext_block;
    end

    // R8: display area is uncached when its bit is set
    a_r8_video_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && lookup_addr >= 32'h000A_0000 && lookup_addr < 32'h0010_0000)
        |-> !cacheable);

    // R9: low 64 KB of each megabyte is uncached in legacy mode
    a_r9_low64_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (low64_en && legacy_mode && lookup_addr[19:16] == 4'h0) |-> !cacheable);

    // R10: gated external enable blocks caching while deasserted
    a_r10_ext_block: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && ext_cache_en_n) |-> !cacheable);
endmodule

// File: tb/uncached_window_unit_test.sv
module uncached_window_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_idx = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [31:0] lookup_addr = 32'h0;
    logic        legacy_mode = 1'b0;
    logic        ext_cache_en_n = 1'b1;
    logic        cacheable;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    uncached_window_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lookup_addr(lookup_addr),
        .legacy_mode(legacy_mode), .ext_cache_en_n(ext_cache_en_n),
        .cacheable(cacheable)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  idx;
        logic [7:0]  data;
        logic [31:0] addr;
        logic        mode;
        logic        extn;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 8'h00, 32'h000A_0000, 1'b1, 1'b1, 1'b1, 4'd1},  // R1, R10 ignored
        '{1'b1, 8'hC0, 8'h02, 32'h000A_0000, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
        '{1'b0, 8'h00, 8'h00, 32'h0009_FFFF, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 below
        '{1'b0, 8'h00, 8'h00, 32'h000F_FFFF, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 top
        '{1'b0, 8'h00, 8'h00, 32'h0010_0000, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 above
        '{1'b1, 8'hC0, 8'h03, 32'h0030_0000, 1'b1, 1'b1, 1'b0, 4'd9},  // R9
        '{1'b0, 8'h00, 8'h00, 32'h0031_0000, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 past 64K
        '{1'b0, 8'h00, 8'h00, 32'h0030_0000, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 mode off
        '{1'b1, 8'hC0, 8'h00, 32'h0030_0000, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 clear
        '{1'b1, 8'hC4, 8'h12, 32'h1234_0000, 1'b0, 1'b1, 1'b1, 4'd4},  // R4
        '{1'b1, 8'hC5, 8'h34, 32'h1234_0000, 1'b0, 1'b1, 1'b1, 4'd4},  // R4
        '{1'b1, 8'hC6, 8'h55, 32'h1234_0000, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 aligned base
        '{1'b0, 8'h00, 8'h00, 32'h1234_FFFF, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 last byte
        '{1'b0, 8'h00, 8'h00, 32'h1235_0000, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 past end
        '{1'b0, 8'h00, 8'h00, 32'h1233_FFFF, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 before base
        '{1'b1, 8'hCD, 8'h80, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 4'd4},  // R4
        '{1'b1, 8'hCF, 8'h01, 32'h8000_0FFF, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 4 KB
        '{1'b0, 8'h00, 8'h00, 32'h8000_1000, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 4 KB end
        '{1'b1, 8'hC7, 8'h40, 32'h41FF_FFFF, 1'b0, 1'b1, 1'b1, 4'd4},  // R4
        '{1'b1, 8'hC9, 8'h0E, 32'h41FF_FFFF, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 32 MB
        '{1'b0, 8'h00, 8'h00, 32'h4200_0000, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 32 MB end
        '{1'b1, 8'hC2, 8'hFF, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 4'd3},  // R3
        '{1'b1, 8'hC1, 8'h01, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 4'd11}, // R11
        '{1'b1, 8'hC0, 8'h08, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 4'd10}, // R10
        '{1'b0, 8'h00, 8'h00, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
        '{1'b1, 8'hC0, 8'h00, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 4'd10}, // R10 ignored
        '{1'b1, 8'hCC, 8'h0F, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 4'd7},  // R7
        '{1'b0, 8'h00, 8'h00, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 4'd7},  // R7
        '{1'b1, 8'hCC, 8'h00, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 4'd4}   // R4 off again
    };

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: cacheable=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [7:0] idx, input logic [7:0] exp);
        @(negedge clk);
        cfg_idx = idx;
        #1;
        applied++;
        if (cfg_rdata !== exp) begin
            bad++;
            $display("FAIL %s: rdata[%h]=%h expected %h", tag, idx, cfg_rdata, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: every index reads zero after reset
        for (int i = 'hC0; i <= 'hCF; i++) chk_rd("R1 reset readback", 8'(i), 8'h00);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cfg_wr = VECS[v].wr; cfg_idx = VECS[v].idx; cfg_wdata = VECS[v].data;
            lookup_addr = VECS[v].addr; legacy_mode = VECS[v].mode;
            ext_cache_en_n = VECS[v].extn;
            @(posedge clk);
            #2;
            cfg_wr = 1'b0;
            chk_bit($sformatf("vector %0d req R%0d", v, VECS[v].req), cacheable, VECS[v].exp);
        end

        chk_rd("R2 window byte", 8'hC6, 8'h55);
        chk_rd("R2 window byte", 8'hCD, 8'h80);
        chk_rd("R11 control 1", 8'hC1, 8'h01);
        chk_rd("R3 hole C2", 8'hC2, 8'h00);
        wr_byte(8'hD0, 8'h30);
        chk_rd("R3 above range", 8'hD0, 8'h00);
        wr_byte(8'h10, 8'h30);
        chk_rd("R3 below range", 8'h10, 8'h00);
        chk_rd("R3 bank intact", 8'hC4, 8'h12);

        // R12: address changes between edges are seen at once
        @(posedge clk);
        #1; lookup_addr = 32'h1234_8000; ext_cache_en_n = 1'b1; legacy_mode = 1'b0;
        #1; chk_bit("R12 inside window", cacheable, 1'b0);
        lookup_addr = 32'h0500_0000;
        #1; chk_bit("R12 outside window", cacheable, 1'b1);

        // R1: a second reset clears a live configuration
        do_reset();
        #1;
        lookup_addr = 32'h1234_0000;
        #1; chk_bit("R1 after reset", cacheable, 1'b1);
        chk_rd("R1 window cleared", 8'hC6, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end
endmodule